// File: doc/BRIEF.md
# Sixteen-Bit Capture / Up-Down Timer

This block is a single 16-bit timer/counter paired with one 16-bit reload/capture register. One counter covers every job. It can auto-reload from the register when it overflows. It can count down to a floor taken from the register and then restart at all ones. It can copy its running value into the register when an external pin falls. It can toggle a clock output on every wrap.

Counting steps come from a prescaler on the system clock. The default divide ratio is 12, and 4 or 13 can be selected instead. The counter and the register can be written at any time. Sticky flags record wraps and external events, and each flag has its own clear input. A direction-status bit toggles on every wrap while up/down counting is enabled.

Top module: `cap_timer16`

## Requirements
- R1: While `rst_n` is low, `count`, `rld_cap`, `ovf_flag`, `ext_flag`, `dir_stat` and `clk_out` are all 0.
- R2: While `run` is 1, a count step happens once every N system clocks. `tick_sel` selects N: 2'b00 gives 12, 2'b01 gives 4, 2'b10 gives 13 and 2'b11 gives 12. While `run` is 0 the prescaler is held at zero and the counter does not step. The first step after `run` rises comes N clocks later.
- R3: When counting up, a step from 0xFFFF is a wrap. The counter then loads `rld_cap` when `mode_cap`=0, or rolls to 0 when `mode_cap`=1, and `ovf_flag` is set. Any other up step adds one.
- R4: The counter counts down when `ud_en`=1, `mode_cap`=0 and `dir_in`=0. A down step taken while `count` equals `rld_cap` is a wrap: it loads 0xFFFF and sets `ovf_flag`. Any other down step subtracts one.
- R5: `dir_stat` inverts on every wrap while `ud_en`=1. It holds its value at all other times.
- R6: `ext_trig` passes through a two-flop synchronizer, and a falling edge is detected after the synchronizer. When `ext_en`=1, a fall of `ext_trig` sets `ext_flag` at the third rising clock edge after the fall. When `ext_en`=0, a fall has no effect.
- R7: When `mode_cap`=1, a detected external event copies the `count` value held at that edge into `rld_cap`.
- R8: When `mode_cap`=0 and `ud_en`=0, a detected external event loads `count` from `rld_cap`, and that cycle's step is dropped.
- R9: `clk_out` inverts on every wrap while `clkout_en`=1, so it runs at half the wrap rate. Otherwise it holds its value.
- R10: A `cnt_wr_en` write takes priority over both an external reload and a step. A `rld_wr_en` write takes priority over a capture. Reloads use the value `rld_cap` held before the edge.
- R11: `ovf_clr` clears `ovf_flag` and `ext_clr` clears `ext_flag`. When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables the prescaler and counting |
| tick_sel | input | 2 | Prescale ratio select |
| mode_cap | input | 1 | 1 selects capture mode, 0 selects auto-reload |
| ud_en | input | 1 | Enables direction control from `dir_in` |
| dir_in | input | 1 | Direction when `ud_en`=1: 1 counts up, 0 counts down |
| ext_en | input | 1 | Enables response to the external trigger |
| ext_trig | input | 1 | Asynchronous external trigger, acting on its falling edge |
| clkout_en | input | 1 | Enables toggling of `clk_out` on wraps |
| cnt_wr_en | input | 1 | Writes `cnt_wr_data` into the counter |
| cnt_wr_data | input | 16 | Counter write value |
| rld_wr_en | input | 1 | Writes `rld_wr_data` into the reload/capture register |
| rld_wr_data | input | 16 | Reload/capture write value |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| ext_clr | input | 1 | Clears `ext_flag` |
| count | output | 16 | Running counter value |
| rld_cap | output | 16 | Reload/capture register |
| ovf_flag | output | 1 | Sticky wrap flag |
| ext_flag | output | 1 | Sticky external-event flag |
| dir_stat | output | 1 | Direction status, toggled on each wrap in up/down mode |
| clk_out | output | 1 | Programmable output clock |

## Verification
The bench builds the block with its default parameters: 16-bit count, divide ratios of 12, 4 and 13, and two synchronizer stages. At these widths the counter only reaches its wraps because the bench preloads it near 0xFFFF or near the down-count floor. The divide-by-4 setting then gives many wraps, reload and roll-over cases, and clock-output toggles within a few hundred cycles. The divide-by-12 and divide-by-13 ratios are checked over shorter windows. External falls are timed against steps so that capture, external reload and write priority all meet in the same cycles.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    TSEL_SLOW  = 2'b00,
    TSEL_FAST  = 2'b01,
    TSEL_ODD   = 2'b10,
    TSEL_SLOW2 = 2'b11
  } tick_sel_e;

  // Divide ratio chosen by the select code.
  function automatic int unsigned tick_divisor(input logic [1:0] sel,
                                               input int unsigned d_slow,
                                               input int unsigned d_fast,
                                               input int unsigned d_odd);
    case (tick_sel_e'(sel))
      TSEL_FAST: return d_fast;
      TSEL_ODD:  return d_odd;
      default:   return d_slow;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
  import tmr16_pkg::*;
#(
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_ODD  = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int unsigned DIV_MAX = max3(DIV_SLOW, DIV_FAST, DIV_ODD);
  localparam int unsigned PW      = $clog2(DIV_MAX + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last_q;

  always_comb begin
    last_q = PW'(tick_divisor(sel, DIV_SLOW, DIV_FAST, DIV_ODD) - 1);
    tick   = run && (pre_q >= last_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!run)   pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= din;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ext_fall,
  input  logic             mode_cap,
  input  logic             ud_en,
  input  logic             dir_in,
  input  logic             ext_en,
  input  logic             clkout_en,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             rld_wr_en,
  input  logic [CNT_W-1:0] rld_wr_data,
  input  logic             ovf_clr,
  input  logic             ext_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rld_cap,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             dir_stat,
  output logic             clk_out,
  output logic             wrap_evt,
  output logic             ext_evt,
  output logic             ext_reload,
  output logic             down_mode
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] next_up(input logic [CNT_W-1:0] v,
                                               input logic [CNT_W-1:0] rld,
                                               input logic cap);
    if (v == CNT_MAX) return cap ? '0 : rld;
    return v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] next_down(input logic [CNT_W-1:0] v,
                                                 input logic [CNT_W-1:0] rld);
    if (v == rld) return CNT_MAX;
    return v - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic             ovf_q, ext_q, dir_q, clko_q;
  logic             step_go, at_limit, cap_go;

  always_comb begin
    down_mode  = ud_en && !mode_cap && !dir_in;
    ext_evt    = ext_fall && ext_en;
    ext_reload = ext_evt && !mode_cap && !ud_en;
    cap_go     = ext_evt && mode_cap;
    step_go    = tick && !cnt_wr_en && !ext_reload;
    at_limit   = down_mode ? (cnt_q == rld_q) : (cnt_q == CNT_MAX);
    wrap_evt   = step_go && at_limit;

    if (cnt_wr_en)       cnt_d = cnt_wr_data;
    else if (ext_reload) cnt_d = rld_q;
    else if (step_go)    cnt_d = down_mode ? next_down(cnt_q, rld_q)
                                           : next_up(cnt_q, rld_q, mode_cap);
    else                 cnt_d = cnt_q;

    if (rld_wr_en)   rld_d = rld_wr_data;
    else if (cap_go) rld_d = cnt_q;
    else             rld_d = rld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ovf_q  <= 1'b0;
      ext_q  <= 1'b0;
      dir_q  <= 1'b0;
      clko_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      if (wrap_evt)     ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (ext_evt)      ext_q <= 1'b1;
      else if (ext_clr) ext_q <= 1'b0;
      if (wrap_evt && ud_en)     dir_q  <= ~dir_q;
      if (wrap_evt && clkout_en) clko_q <= ~clko_q;
    end
  end

  assign count    = cnt_q;
  assign rld_cap  = rld_q;
  assign ovf_flag = ovf_q;
  assign ext_flag = ext_q;
  assign dir_stat = dir_q;
  assign clk_out  = clko_q;
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16 #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DIV_SLOW    = 12,
  parameter int unsigned DIV_FAST    = 4,
  parameter int unsigned DIV_ODD     = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       tick_sel,
  input  logic             mode_cap,
  input  logic             ud_en,
  input  logic             dir_in,
  input  logic             ext_en,
  input  logic             ext_trig,
  input  logic             clkout_en,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             rld_wr_en,
  input  logic [CNT_W-1:0] rld_wr_data,
  input  logic             ovf_clr,
  input  logic             ext_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rld_cap,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             dir_stat,
  output logic             clk_out
);
  logic tick, ext_fall, wrap_evt, ext_evt, ext_reload, down_mode;

  tmr16_prescale #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .DIV_ODD(DIV_ODD)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(tick_sel), .tick(tick)
  );

  tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_trig), .fall(ext_fall)
  );

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_fall(ext_fall),
    .mode_cap(mode_cap), .ud_en(ud_en), .dir_in(dir_in), .ext_en(ext_en),
    .clkout_en(clkout_en), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .rld_wr_en(rld_wr_en), .rld_wr_data(rld_wr_data),
    .ovf_clr(ovf_clr), .ext_clr(ext_clr),
    .count(count), .rld_cap(rld_cap), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .dir_stat(dir_stat), .clk_out(clk_out),
    .wrap_evt(wrap_evt), .ext_evt(ext_evt), .ext_reload(ext_reload),
    .down_mode(down_mode)
  );
endmodule

// File: rtl/cap_timer16_chk.sv
module cap_timer16_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             ext_fall,
  input logic             ext_en,
  input logic             mode_cap,
  input logic             ud_en,
  input logic             clkout_en,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic             rld_wr_en,
  input logic             wrap_evt,
  input logic             down_mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] rld_cap,
  input logic             ovf_flag,
  input logic             ext_flag,
  input logic             dir_stat,
  input logic             clk_out
);
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_TICK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag); // R3
  AST_UP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !mode_cap && !down_mode) |=> (count == $past(rld_cap))); // R3
  AST_DOWN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && down_mode) |=> (count == '1)); // R4
  AST_DIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && ud_en) |=> (dir_stat != $past(dir_stat))); // R5
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_evt && ud_en) |=> $stable(dir_stat)); // R5
  AST_EXT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fall && ext_en) |=> ext_flag); // R6
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fall && ext_en && mode_cap && !rld_wr_en) |=> (rld_cap == $past(count))); // R7
  AST_CLKOUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && clkout_en) |=> (clk_out != $past(clk_out))); // R9
  AST_CLKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_evt && clkout_en) |=> $stable(clk_out)); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (count == $past(cnt_wr_data))); // R10
endmodule

bind cap_timer16 cap_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .ext_fall(ext_fall),
  .ext_en(ext_en), .mode_cap(mode_cap), .ud_en(ud_en), .clkout_en(clkout_en),
  .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .rld_wr_en(rld_wr_en),
  .wrap_evt(wrap_evt), .down_mode(down_mode), .count(count), .rld_cap(rld_cap),
  .ovf_flag(ovf_flag), .ext_flag(ext_flag), .dir_stat(dir_stat),
  .clk_out(clk_out)
);

// File: tb/cap_timer16_bench.sv
`timescale 1ns/1ps
module cap_timer16_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, mode_cap = 0, ud_en = 0, dir_in = 1, ext_en = 0;
  logic ext_trig = 1, clkout_en = 0, cnt_wr_en = 0, rld_wr_en = 0;
  logic ovf_clr = 0, ext_clr = 0;
  logic [1:0]  tick_sel = 2'b00;
  logic [15:0] cnt_wr_data = '0, rld_wr_data = '0;
  logic [15:0] count, rld_cap;
  logic ovf_flag, ext_flag, dir_stat, clk_out;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cap_timer16 u_cap_timer16 (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_sel(tick_sel),
    .mode_cap(mode_cap), .ud_en(ud_en), .dir_in(dir_in), .ext_en(ext_en),
    .ext_trig(ext_trig), .clkout_en(clkout_en), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_data(cnt_wr_data), .rld_wr_en(rld_wr_en), .rld_wr_data(rld_wr_data),
    .ovf_clr(ovf_clr), .ext_clr(ext_clr), .count(count), .rld_cap(rld_cap),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .dir_stat(dir_stat),
    .clk_out(clk_out)
  );

  // Behavioural reference: integer state, pin history kept in a queue.
  int m_pre, m_cnt, m_rld;
  bit m_ovf, m_ext, m_dir, m_clk;
  bit pin_hist[$];

  task automatic model_reset();
    m_pre = 0; m_cnt = 0; m_rld = 0;
    m_ovf = 0; m_ext = 0; m_dir = 0; m_clk = 0;
    pin_hist = '{1, 1, 1};
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int div, ncnt, nrld;
      bit stepping, fell, evt, reld, down, wrapped;
      div = (tick_sel == 2'b01) ? 4 : (tick_sel == 2'b10) ? 13 : 12;
      stepping = run && (m_pre == div - 1);
      if (!run || stepping) m_pre = 0; else m_pre++;
      // pin_hist[0] newest synchronized sample, [1] one edge older
      fell = pin_hist[2] && !pin_hist[1];
      pin_hist.push_front(ext_trig);
      void'(pin_hist.pop_back());
      evt  = fell && ext_en;
      reld = evt && !mode_cap && !ud_en;
      down = ud_en && !mode_cap && !dir_in;
      wrapped = 0;
      ncnt = m_cnt;
      if (cnt_wr_en) ncnt = cnt_wr_data;
      else if (reld) ncnt = m_rld;
      else if (stepping) begin
        if (down) begin
          if (m_cnt == m_rld) begin ncnt = 65535; wrapped = 1; end
          else ncnt = m_cnt - 1;
        end else begin
          if (m_cnt == 65535) begin ncnt = mode_cap ? 0 : m_rld; wrapped = 1; end
          else ncnt = m_cnt + 1;
        end
      end
      nrld = m_rld;
      if (rld_wr_en) nrld = rld_wr_data;
      else if (evt && mode_cap) nrld = m_cnt;
      m_cnt = ncnt; m_rld = nrld;
      if (wrapped) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (evt) m_ext = 1; else if (ext_clr) m_ext = 0;
      if (wrapped && ud_en) m_dir = ~m_dir;
      if (wrapped && clkout_en) m_clk = ~m_clk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3/R4/R8/R10 count", int'(count), m_cnt);
      chk("R7/R10 rld_cap", int'(rld_cap), m_rld);
      chk("R3/R4/R11 ovf_flag", int'(ovf_flag), int'(m_ovf));
      chk("R6/R11 ext_flag", int'(ext_flag), int'(m_ext));
      chk("R5 dir_stat", int'(dir_stat), int'(m_dir));
      chk("R9 clk_out", int'(clk_out), int'(m_clk));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_wr_data = v; cnt_wr_en = 1; wait_cyc(1); cnt_wr_en = 0;
  endtask

  task automatic wr_rld(input logic [15:0] v);
    rld_wr_data = v; rld_wr_en = 1; wait_cyc(1); rld_wr_en = 0;
  endtask

  task automatic pulse_trig(input int low, input int high);
    ext_trig = 0; wait_cyc(low); ext_trig = 1; wait_cyc(high);
  endtask

  task automatic clear_flags();
    ovf_clr = 1; ext_clr = 1; wait_cyc(1); ovf_clr = 0; ext_clr = 0;
  endtask

  initial begin
    wait_cyc(3);
    // R1: reset values
    chk("R1 count", int'(count), 0);
    chk("R1 rld_cap", int'(rld_cap), 0);
    chk("R1 flags", int'({ovf_flag, ext_flag, dir_stat, clk_out}), 0);
    rst_n = 1;

    // R2: divide by 4, first step 4 clocks after run rises
    tick_sel = 2'b01; run = 1;
    wait_cyc(40);
    chk("R2 div4 count", int'(count), 10);
    tick_sel = 2'b00; wait_cyc(130);
    tick_sel = 2'b10; wait_cyc(140);
    tick_sel = 2'b11; wait_cyc(50);
    run = 0; wait_cyc(20);

    // R3/R9: auto-reload wraps with clock output
    tick_sel = 2'b01; clkout_en = 1;
    wr_rld(16'h1234); wr_cnt(16'hFFF8);
    run = 1; wait_cyc(120);
    wr_rld(16'hFFF0); wait_cyc(300);
    clkout_en = 0; wait_cyc(100);

    // R3: capture mode rolls to zero
    mode_cap = 1; wr_cnt(16'hFFFA); wait_cyc(60);

    // R6/R7: capture on external falls, R10 write over capture
    ext_en = 1;
    pulse_trig(6, 9); pulse_trig(3, 11); pulse_trig(1, 7);
    rld_wr_data = 16'hABCD; rld_wr_en = 1; ext_trig = 0; wait_cyc(3);
    rld_wr_en = 0; ext_trig = 1; wait_cyc(8);
    clear_flags(); wait_cyc(4);
    chk("R11 flags cleared", int'({ovf_flag, ext_flag}), 0);

    // R8: external reload in auto-reload mode
    mode_cap = 0; wr_rld(16'h0100); wr_cnt(16'h0050);
    pulse_trig(5, 13); pulse_trig(2, 10);
    for (int k = 0; k < 6; k++) begin
      pulse_trig(1 + k, 5);
      cnt_wr_data = 16'h0200 + 16'(k); cnt_wr_en = (k % 2 == 0);
      wait_cyc(1); cnt_wr_en = 0;
    end

    // R6: falls ignored while disabled
    ext_en = 0; clear_flags(); wr_cnt(16'h0300);
    run = 0; pulse_trig(4, 10);
    chk("R6 ignored ext_flag", int'(ext_flag), 0);
    chk("R6 ignored count", int'(count), 16'h0300);
    run = 1;

    // R4/R5: down counting to the floor, then up again
    ud_en = 1; dir_in = 0; clkout_en = 1;
    wr_rld(16'h0010); wr_cnt(16'h0014);
    wait_cyc(120);
    chk("R5 dir toggled", int'(dir_stat), int'(m_dir));
    wr_cnt(16'hFFFD); wait_cyc(80);
    dir_in = 1; wr_cnt(16'hFFFC); wait_cyc(80);
    ext_en = 1; pulse_trig(3, 10);
    dir_in = 0; wr_cnt(16'h0011); wait_cyc(60);

    // R11: set beats clear in the same cycle
    ovf_clr = 1; wait_cyc(60); ovf_clr = 0;
    tick_sel = 2'b10; wait_cyc(200);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule